// File: doc/BRIEF.md
# Register Rename Map with Committed Checkpoint

This block translates architectural register numbers into physical register numbers for a machine that renames registers explicitly, with more physical registers than architectural ones. Each issued instruction reads its two source operands through the speculative map. If it writes a result, the block also takes a free physical register for its destination and records that choice in the speculative map.

A second map follows retirement only. When an instruction commits, its destination mapping is copied into the committed map. The physical register that the committed map held for that architectural register before the copy goes back to the pool. On a misprediction the pipeline pulses `restart`. The committed map is then copied over the speculative map, and the pool is rebuilt from scratch so that it holds every physical register the committed map does not name.

The pool is a bit vector with one bit per physical register. The free register with the lowest index is always the next one handed out.

Top module: `rename_map`

## Requirements
- R1: After reset both maps send architectural register i to physical register i. The pool holds physical registers NUM_ARCH to NUM_PHYS-1, so the first allocation returns NUM_ARCH.
- R2: `iss_psrc_a` and `iss_psrc_b` come combinationally from the speculative map as it stood before the current cycle. A destination remapped in the same cycle does not change them.
- R3: An accepted issue with `iss_has_dst`=1 takes the lowest-numbered free physical register, reported on `iss_pdst`. From the next cycle on, the speculative map sends `iss_dst` to that register.
- R4: `iss_ready` is 0 when `iss_has_dst`=1 and the pool is empty. An issue that is not accepted, or that has `iss_valid`=0, changes neither the map nor the pool.
- R5: An issue with `iss_has_dst`=0 allocates nothing, and `iss_ready` is 1 for it even when the pool is empty.
- R6: A commit (`cmt_valid`, `cmt_arch`, `cmt_phys`) writes `cmt_phys` into the committed map. The register the committed map held for `cmt_arch` before the write returns to the pool and can be allocated from the next cycle on.
- R7: A register freed by a commit cannot be allocated in the same cycle as that commit.
- R8: `restart` copies the committed map into the speculative map, including a commit made in the same cycle. An issue presented in a restart cycle is discarded.
- R9: On `restart` the pool is rebuilt to hold exactly the physical registers that the committed map does not name after that cycle's commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_has_dst | input | 1 | The offered instruction writes a register |
| iss_dst | input | $clog2(NUM_ARCH) | Architectural destination |
| iss_src_a | input | $clog2(NUM_ARCH) | Architectural source A |
| iss_src_b | input | $clog2(NUM_ARCH) | Architectural source B |
| iss_ready | output | 1 | The issue can be accepted |
| iss_pdst | output | $clog2(NUM_PHYS) | Physical register granted to the destination |
| iss_psrc_a | output | $clog2(NUM_PHYS) | Physical register for source A |
| iss_psrc_b | output | $clog2(NUM_PHYS) | Physical register for source B |
| cmt_valid | input | 1 | One mapping retires |
| cmt_arch | input | $clog2(NUM_ARCH) | Architectural register of the retiring mapping |
| cmt_phys | input | $clog2(NUM_PHYS) | Physical register of the retiring mapping |
| restart | input | 1 | Roll the speculative state back to the committed state |

## Verification
The bench builds the block with NUM_ARCH=4 and NUM_PHYS=8, which leaves four spare physical registers. With so few spares, a handful of issues empties the pool. That brings the stall, the issue without a destination while the pool is empty, and a commit whose freed register cannot be taken in the same cycle into a short vector walk. The small maps also make the whole committed state visible through a few source lookups after a restart. The rebuilt pool shows up in the order of the allocations that follow, including the case of a commit and a restart in the same cycle.

// File: rtl/rename_pkg.sv
package rename_pkg;

    localparam int DEF_ARCH_REGS = 32;
    localparam int DEF_PHYS_REGS = 64;

    // index width for a table of n entries, never below one bit
    function automatic int idx_w(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rn_first_free.sv
module rn_first_free #(
    parameter int NUM_PHYS = 64,
    localparam int PW = rename_pkg::idx_w(NUM_PHYS)
) (
    input  logic [NUM_PHYS-1:0] mask,
    output logic                found,
    output logic [PW-1:0]       idx
);

    // scan from the top down so that the lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NUM_PHYS - 1; k >= 0; k--) begin
            if (mask[k]) begin
                found = 1'b1;
                idx   = PW'(k);
            end
        end
    end

endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
    parameter int NUM_ARCH = 32,
    parameter int NUM_PHYS = 64,
    localparam int PW = rename_pkg::idx_w(NUM_PHYS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         take,
    input  logic                         give,
    input  logic [PW-1:0]                give_idx,
    input  logic                         rebuild,
    input  logic [NUM_ARCH-1:0][PW-1:0]  cmt_map,
    output logic                         has_free,
    output logic [PW-1:0]                first_idx
);

    logic [NUM_PHYS-1:0] free_q;
    logic [NUM_PHYS-1:0] free_n;
    logic [NUM_PHYS-1:0] used;

    rn_first_free #(.NUM_PHYS(NUM_PHYS)) u_pick (
        .mask  (free_q),
        .found (has_free),
        .idx   (first_idx)
    );

    always_comb begin
        used = '0;
        for (int a = 0; a < NUM_ARCH; a++) begin
            used[cmt_map[a]] = 1'b1;
        end
    end

    always_comb begin
        free_n = free_q;
        if (rebuild) begin
            free_n = ~used;
        end else begin
            if (take) free_n[first_idx] = 1'b0;
            if (give) free_n[give_idx]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_PHYS; k++) begin
                free_q[k] <= (k >= NUM_ARCH);
            end
        end else begin
            free_q <= free_n;
        end
    end

    AST_TAKE_FROM_POOL: assert property (@(posedge clk) disable iff (rst)
        take |-> free_q[first_idx]);                                // R3
    AST_TAKEN_LEAVES_POOL: assert property (@(posedge clk) disable iff (rst)
        (take && !rebuild) |=> !free_q[$past(first_idx)]);          // R3
    AST_GIVE_WAS_BUSY: assert property (@(posedge clk) disable iff (rst)
        give |-> !free_q[give_idx]);                                // R6
    AST_GIVE_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (give && !rebuild) |=> free_q[$past(give_idx)]);            // R6

endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NUM_ARCH = 32,
    parameter int NUM_PHYS = 64,
    localparam int AW = rename_pkg::idx_w(NUM_ARCH),
    localparam int PW = rename_pkg::idx_w(NUM_PHYS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [AW-1:0]                rd_a_idx,
    input  logic [AW-1:0]                rd_b_idx,
    output logic [PW-1:0]                rd_a,
    output logic [PW-1:0]                rd_b,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_idx,
    input  logic [PW-1:0]                wr_phys,
    input  logic                         cm_en,
    input  logic [AW-1:0]                cm_idx,
    input  logic [PW-1:0]                cm_phys,
    output logic [PW-1:0]                cm_old,
    input  logic                         restart,
    output logic [NUM_ARCH-1:0][PW-1:0]  cmt_nxt
);

    logic [NUM_ARCH-1:0][PW-1:0] spec_q;
    logic [NUM_ARCH-1:0][PW-1:0] cmt_q;

    assign rd_a   = spec_q[rd_a_idx];
    assign rd_b   = spec_q[rd_b_idx];
    assign cm_old = cmt_q[cm_idx];

    for (genvar i = 0; i < NUM_ARCH; i++) begin : g_ent
        assign cmt_nxt[i] = (cm_en && cm_idx == AW'(i)) ? cm_phys : cmt_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                spec_q[i] <= PW'(i);
                cmt_q[i]  <= PW'(i);
            end else begin
                cmt_q[i] <= cmt_nxt[i];
                if (restart)
                    spec_q[i] <= cmt_nxt[i];
                else if (wr_en && wr_idx == AW'(i))
                    spec_q[i] <= wr_phys;
            end
        end

        AST_RESTART_COPY: assert property (@(posedge clk) disable iff (rst)
            restart |=> spec_q[i] == cmt_q[i]);                     // R8
        AST_SPEC_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!restart && !(wr_en && wr_idx == AW'(i))) |=> $stable(spec_q[i])); // R4
    end

endmodule

// File: rtl/rename_map.sv
module rename_map #(
    parameter int NUM_ARCH = rename_pkg::DEF_ARCH_REGS,
    parameter int NUM_PHYS = rename_pkg::DEF_PHYS_REGS,
    localparam int AW = rename_pkg::idx_w(NUM_ARCH),
    localparam int PW = rename_pkg::idx_w(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iss_valid,
    input  logic          iss_has_dst,
    input  logic [AW-1:0] iss_dst,
    input  logic [AW-1:0] iss_src_a,
    input  logic [AW-1:0] iss_src_b,
    output logic          iss_ready,
    output logic [PW-1:0] iss_pdst,
    output logic [PW-1:0] iss_psrc_a,
    output logic [PW-1:0] iss_psrc_b,
    input  logic          cmt_valid,
    input  logic [AW-1:0] cmt_arch,
    input  logic [PW-1:0] cmt_phys,
    input  logic          restart
);

    logic                         has_free;
    logic [PW-1:0]                cm_old;
    logic [NUM_ARCH-1:0][PW-1:0]  cmt_nxt;
    logic                         alloc;

    assign iss_ready = !iss_has_dst || has_free;
    assign alloc     = iss_valid && iss_has_dst && has_free && !restart;

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_maps (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (iss_src_a),
        .rd_b_idx (iss_src_b),
        .rd_a     (iss_psrc_a),
        .rd_b     (iss_psrc_b),
        .wr_en    (alloc),
        .wr_idx   (iss_dst),
        .wr_phys  (iss_pdst),
        .cm_en    (cmt_valid),
        .cm_idx   (cmt_arch),
        .cm_phys  (cmt_phys),
        .cm_old   (cm_old),
        .restart  (restart),
        .cmt_nxt  (cmt_nxt)
    );

    rn_free_pool #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_pool (
        .clk       (clk),
        .rst       (rst),
        .take      (alloc),
        .give      (cmt_valid),
        .give_idx  (cm_old),
        .rebuild   (restart),
        .cmt_map   (cmt_nxt),
        .has_free  (has_free),
        .first_idx (iss_pdst)
    );

    AST_PDST_IS_SPARE: assert property (@(posedge clk) disable iff (rst)
        alloc |=> iss_pdst != $past(iss_pdst) || !has_free);        // R3

endmodule

// File: tb/sim_rename_map.sv
module sim_rename_map;

    localparam int A  = 4;
    localparam int P  = 8;
    localparam int AW = 2;
    localparam int PW = 3;

    typedef struct packed {
        logic          iv;
        logic          hd;
        logic [AW-1:0] dst;
        logic [AW-1:0] sa;
        logic [AW-1:0] sb;
        logic          cv;
        logic [AW-1:0] ca;
        logic [PW-1:0] cp;
        logic          rs;
        logic          er;
        logic [PW-1:0] ep;
        logic [PW-1:0] ea;
        logic [PW-1:0] eb;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b1,2'd1,2'd1,2'd2,1'b0,2'd0,3'd0,1'b0,1'b1,3'd4,3'd1,3'd2,4'd3}, // R3 first grant
        '{1'b1,1'b1,2'd2,2'd1,2'd2,1'b0,2'd0,3'd0,1'b0,1'b1,3'd5,3'd4,3'd2,4'd2}, // R2
        '{1'b1,1'b1,2'd1,2'd1,2'd3,1'b0,2'd0,3'd0,1'b0,1'b1,3'd6,3'd4,3'd3,4'd2}, // R2 src==dst
        '{1'b1,1'b0,2'd0,2'd1,2'd2,1'b0,2'd0,3'd0,1'b0,1'b1,3'd7,3'd6,3'd5,4'd5}, // R5
        '{1'b1,1'b1,2'd3,2'd3,2'd0,1'b0,2'd0,3'd0,1'b0,1'b1,3'd7,3'd3,3'd0,4'd3}, // R3 last spare
        '{1'b1,1'b1,2'd0,2'd0,2'd1,1'b0,2'd0,3'd0,1'b0,1'b0,3'd0,3'd0,3'd6,4'd4}, // R4 stall
        '{1'b1,1'b0,2'd0,2'd3,2'd2,1'b0,2'd0,3'd0,1'b0,1'b1,3'd0,3'd7,3'd5,4'd5}, // R5 empty
        '{1'b1,1'b1,2'd0,2'd0,2'd0,1'b1,2'd1,3'd4,1'b0,1'b0,3'd0,3'd0,3'd0,4'd7}, // R7
        '{1'b1,1'b1,2'd0,2'd0,2'd0,1'b0,2'd0,3'd0,1'b0,1'b1,3'd1,3'd0,3'd0,4'd6}, // R6
        '{1'b0,1'b0,2'd0,2'd2,2'd3,1'b1,2'd2,3'd5,1'b0,1'b1,3'd2,3'd5,3'd7,4'd6}, // R6
        '{1'b1,1'b1,2'd2,2'd2,2'd1,1'b1,2'd1,3'd6,1'b0,1'b1,3'd2,3'd5,3'd6,4'd6}, // R6 give+take
        '{1'b1,1'b1,2'd3,2'd0,2'd3,1'b0,2'd0,3'd0,1'b1,1'b1,3'd4,3'd1,3'd7,4'd8}, // R8
        '{1'b1,1'b1,2'd0,2'd1,2'd3,1'b0,2'd0,3'd0,1'b0,1'b1,3'd1,3'd6,3'd3,4'd9}, // R9
        '{1'b1,1'b1,2'd1,2'd0,2'd2,1'b0,2'd0,3'd0,1'b0,1'b1,3'd2,3'd1,3'd5,4'd9}, // R9
        '{1'b0,1'b0,2'd0,2'd0,2'd1,1'b1,2'd0,3'd1,1'b1,1'b1,3'd4,3'd1,3'd2,4'd8}, // R8 commit+restart
        '{1'b1,1'b1,2'd3,2'd0,2'd3,1'b0,2'd0,3'd0,1'b0,1'b1,3'd0,3'd1,3'd3,4'd9}, // R9
        '{1'b1,1'b1,2'd2,2'd2,2'd1,1'b0,2'd0,3'd0,1'b0,1'b1,3'd2,3'd5,3'd6,4'd9}, // R9
        '{1'b1,1'b1,2'd1,2'd3,2'd0,1'b0,2'd0,3'd0,1'b0,1'b1,3'd4,3'd0,3'd1,4'd3},
        '{1'b1,1'b1,2'd0,2'd1,2'd2,1'b0,2'd0,3'd0,1'b0,1'b1,3'd7,3'd4,3'd2,4'd3},
        '{1'b1,1'b1,2'd0,2'd0,2'd3,1'b0,2'd0,3'd0,1'b0,1'b0,3'd0,3'd7,3'd0,4'd4}  // R4
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          iss_valid, iss_has_dst;
    logic [AW-1:0] iss_dst, iss_src_a, iss_src_b;
    logic          iss_ready;
    logic [PW-1:0] iss_pdst, iss_psrc_a, iss_psrc_b;
    logic          cmt_valid;
    logic [AW-1:0] cmt_arch;
    logic [PW-1:0] cmt_phys;
    logic          restart;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rename_map #(.NUM_ARCH(A), .NUM_PHYS(P)) u0 (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_has_dst(iss_has_dst), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_ready(iss_ready), .iss_pdst(iss_pdst),
        .iss_psrc_a(iss_psrc_a), .iss_psrc_b(iss_psrc_b),
        .cmt_valid(cmt_valid), .cmt_arch(cmt_arch), .cmt_phys(cmt_phys),
        .restart(restart)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        iss_valid = 0; iss_has_dst = 0; iss_dst = 0; iss_src_a = 0; iss_src_b = 0;
        cmt_valid = 0; cmt_arch = 0; cmt_phys = 0; restart = 0;
    endtask

    task automatic check_reset_state(input string tag);
        for (int r = 0; r < A; r += 2) begin
            @(negedge clk);
            idle();
            iss_has_dst = 1; iss_src_a = AW'(r); iss_src_b = AW'(r + 1);
            #1;
            check(tag, "psrc_a", iss_psrc_a, r);
            check(tag, "psrc_b", iss_psrc_b, r + 1);
            check(tag, "ready", iss_ready, 1);
            check(tag, "pdst", iss_pdst, A);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: identity maps and spare registers after reset
        check_reset_state("R1");

        // R4: has_dst without iss_valid takes nothing
        @(negedge clk);
        idle();
        iss_has_dst = 1; iss_dst = 0;
        @(negedge clk);
        #1;
        check("R4", "pdst after invalid", iss_pdst, A);
        check("R4", "map after invalid", iss_psrc_a, 0);

        for (int v = 0; v < NV; v++) begin
            string tag;
            @(negedge clk);
            iss_valid = VEC[v].iv; iss_has_dst = VEC[v].hd; iss_dst = VEC[v].dst;
            iss_src_a = VEC[v].sa; iss_src_b = VEC[v].sb;
            cmt_valid = VEC[v].cv; cmt_arch = VEC[v].ca; cmt_phys = VEC[v].cp;
            restart = VEC[v].rs;
            #1;
            tag = $sformatf("R%0d v%0d", VEC[v].req, v);
            check(tag, "ready", iss_ready, VEC[v].er);
            if (VEC[v].er && VEC[v].hd) check(tag, "pdst", iss_pdst, VEC[v].ep);
            check(tag, "psrc_a", iss_psrc_a, VEC[v].ea);
            check(tag, "psrc_b", iss_psrc_b, VEC[v].eb);
        end

        // R1: reset in mid-run restores the initial state
        @(negedge clk);
        idle();
        rst = 1;
        @(negedge clk);
        rst = 0;
        check_reset_state("R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule